// File: doc/BRIEF.md
# Recursive Half-Split Unsigned Multiplier

This block multiplies two 32-bit unsigned operands and returns the full 64-bit product through combinational logic alone. It has no clock, no storage and no handshake. When the operands change, the product follows once the adder chains have settled. A surrounding datapath can register it at whatever stage suits its timing.

The product is assembled by recursion. At each level both operands are cut into an upper and a lower half, and four half-width products are formed side by side:

- `lo` is the lower half times the lower half.
- `hi` is the upper half times the upper half.
- Two cross products pair one operand's upper half with the other's lower half.

The two cross products and the upper half of `lo` meet in a three-input carry-save stage. One ripple-carry add resolves that stage into a middle term. A second ripple-carry add places `hi` above the middle term. The lowest half-width bits of the result come straight from `lo` and pass through no adder.

The smallest unit is a 2x2 cell built from four AND gates and two half adders. The same generic core serves widths 2, 4, 8, 16 and 32, so every intermediate width can be used and checked on its own.

Top module: `vc_mult32`

## Requirements
- R1: `product` equals the exact unsigned 64-bit value of `op_a` times `op_b` for any pair of 32-bit operands.
- R2: The 2x2 cell gives bit 0 as a0 AND b0, and bit 1 as the XOR of (a1 AND b0) and (a0 AND b1). Bits 3:2 are (a1 AND b1) plus the carry of that cross-term sum.
- R3: The generic core at each of the widths 2, 4, 8 and 16 returns the exact unsigned product of its two operands, at twice the operand width.
- R4: If either operand is zero, `product` is zero.
- R5: If one operand equals 1, `product` equals the other operand zero-extended to 64 bits.
- R6: Bit 0 of `product` is op_a[0] AND op_b[0]. Bits 15:0 of `product` equal the low 16 bits of op_a[15:0] times op_b[15:0].
- R7: For any nonzero operand, `product[63:32]` is strictly less than that operand.
- R8: All-ones times all-ones gives 64'hFFFF_FFFE_0000_0001. This case needs a carry to propagate through every carry-save and ripple stage.
- R9: Swapping the two operands leaves `product` unchanged, including for operands with alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| product | output | 64 | Unsigned product of op_a and op_b |

## Verification
The bench targets cases where a carry has to cross the full length of the ripple chains:

- **All-ones operands.** A chain that drops its final carry, or a carry-save stage that places its carry vector one bit off, returns a product wrong in its upper word.
- **Alternating bit patterns in both orders.** These expose a swapped cross product or a misaligned `lo` upper half. Such faults give products that depend on operand order or are wrong around bit 16.
- **Operands of 0 and 1.** These catch a zero-extension that picks up stray bits.
- **Each intermediate width on its own.** The 4-bit core is tested exhaustively. A fault in the 2x2 cell therefore shows up at the smallest level rather than only as scattered 64-bit mismatches.

// File: rtl/vc_pkg.sv
package vc_pkg;

    // Operand width of the top-level multiplier.
    localparam int unsigned VC_OPW = 32;

    // Width at which the recursion stops and the 2x2 cell is used.
    localparam int unsigned VC_LEAF_W = 2;

    // Product width for a given operand width.
    function automatic int unsigned vc_prod_w(input int unsigned w);
        return 2 * w;
    endfunction

    // Width of the middle term: one operand width plus two growth bits
    // for the sum of three values.
    function automatic int unsigned vc_mid_w(input int unsigned w);
        return w + 2;
    endfunction

endpackage

// File: rtl/vc_ha.sv
module vc_ha (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    assign s = x ^ y;
    assign c = x & y;
endmodule

// File: rtl/vc_cell2.sv
module vc_cell2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic t_ll, t_hl, t_lh, t_hh;
    logic cross_c;

    // Four partial-product terms.
    assign t_ll = a[0] & b[0];
    assign t_hl = a[1] & b[0];
    assign t_lh = a[0] & b[1];
    assign t_hh = a[1] & b[1];

    assign p[0] = t_ll;

    // Cross terms summed first; their carry joins the high term.
    vc_ha u_ha_cross (.x(t_hl), .y(t_lh), .s(p[1]), .c(cross_c));
    vc_ha u_ha_high  (.x(t_hh), .y(cross_c), .s(p[2]), .c(p[3]));
endmodule

// File: rtl/vc_csa.sv
module vc_csa #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    // Carry vector is returned already shifted one place up.
    // The majority of the top bit is not formed, since the caller
    // sizes W so that it is always zero.
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i] = x[i] ^ y[i] ^ z[i];
        if (i < W - 1) begin : g_maj
            assign c[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
        end
    end
endmodule

// File: rtl/vc_rca.sv
module vc_rca #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    logic [W-1:0] cy;

    // Zero carry-in. The carry out of the top stage is never needed,
    // because W is sized for the largest possible sum.
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign s[i] = x[i] ^ y[i] ^ cy[i];
        if (i < W - 1) begin : g_carry
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
        end
    end
endmodule

// File: rtl/vc_mul.sv
module vc_mul
    import vc_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]              a,
    input  logic [W-1:0]              b,
    output logic [vc_prod_w(W)-1:0]   p
);
    localparam int unsigned H  = W / 2;        // half operand width
    localparam int unsigned MW = vc_mid_w(W);  // middle-term width
    localparam int unsigned UW = 3 * H;        // product bits above the direct slice

    if (W == VC_LEAF_W) begin : g_leaf
        vc_cell2 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
        logic [W-1:0]  sub_lo;
        logic [W-1:0]  sub_hi;
        logic [W-1:0]  sub_x1;
        logic [W-1:0]  sub_x2;
        logic [MW-1:0] cs_sum;
        logic [MW-1:0] cs_cry;
        logic [MW-1:0] mid;
        logic [UW-1:0] upper;

        // Four half-width products, formed in parallel.
        vc_mul #(.W(H)) u_lo (.a(a[H-1:0]), .b(b[H-1:0]), .p(sub_lo));
        vc_mul #(.W(H)) u_hi (.a(a[W-1:H]), .b(b[W-1:H]), .p(sub_hi));
        vc_mul #(.W(H)) u_x1 (.a(a[W-1:H]), .b(b[H-1:0]), .p(sub_x1));
        vc_mul #(.W(H)) u_x2 (.a(a[H-1:0]), .b(b[W-1:H]), .p(sub_x2));

        // Cross products plus the upper half of the low product,
        // reduced to two vectors with no carry propagation.
        vc_csa #(.W(MW)) u_csa (
            .x (MW'(sub_x1)),
            .y (MW'(sub_x2)),
            .z (MW'(sub_lo[W-1:H])),
            .s (cs_sum),
            .c (cs_cry)
        );

        // Resolve the carry-save pair into the middle term.
        vc_rca #(.W(MW)) u_mid_add (.x(cs_sum), .y(cs_cry), .s(mid));

        // Place the high product above the middle term.
        vc_rca #(.W(UW)) u_top_add (
            .x (UW'(mid)),
            .y ({sub_hi, {H{1'b0}}}),
            .s (upper)
        );

        // The low half-width bits come straight from the low product.
        assign p = {upper, sub_lo[H-1:0]};
    end
endmodule

// File: rtl/vc_mult32.sv
module vc_mult32
    import vc_pkg::*;
#(
    parameter int unsigned OPW = VC_OPW
) (
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic [2*OPW-1:0] product
);
    vc_mul #(.W(OPW)) u_core (
        .a (op_a),
        .b (op_b),
        .p (product)
    );
endmodule

// File: rtl/vc_mult32_chk.sv
module vc_mult32_chk #(
    parameter int unsigned OPW = 32
) (
    input logic [OPW-1:0]   op_a,
    input logic [OPW-1:0]   op_b,
    input logic [2*OPW-1:0] product
);
    localparam logic [OPW-1:0]   ONE_OP = OPW'(1);
    localparam logic [2*OPW-1:0] ZERO_P = '0;

    always_comb begin
        if (!$isunknown({op_a, op_b, product})) begin
            AST_ZERO_OPERAND: assert (!((op_a == '0) || (op_b == '0)) || (product == ZERO_P)); // R4
            AST_UNIT_A: assert (op_a != ONE_OP || product == {{OPW{1'b0}}, op_b}); // R5
            AST_UNIT_B: assert (op_b != ONE_OP || product == {{OPW{1'b0}}, op_a}); // R5
            AST_LSB_BIT: assert (product[0] == (op_a[0] & op_b[0])); // R6
            AST_UPPER_BOUND_A: assert (op_a == '0 || product[2*OPW-1:OPW] < op_a); // R7
            AST_UPPER_BOUND_B: assert (op_b == '0 || product[2*OPW-1:OPW] < op_b); // R7
        end
    end
endmodule

bind vc_mult32 vc_mult32_chk #(.OPW(OPW)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
);

// File: tb/tb_vc_mult32.sv
module tb_vc_mult32;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [31:0] op_a, op_b;
    logic [63:0] product;
    logic [1:0]  a2, b2;
    logic [3:0]  p2;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [15:0] a16, b16;
    logic [31:0] p16;

    vc_mult32 dut (.op_a(op_a), .op_b(op_b), .product(product));
    vc_mul #(.W(2))  u_w2  (.a(a2),  .b(b2),  .p(p2));
    vc_mul #(.W(4))  u_w4  (.a(a4),  .b(b4),  .p(p4));
    vc_mul #(.W(8))  u_w8  (.a(a8),  .b(b8),  .p(p8));
    vc_mul #(.W(16)) u_w16 (.a(a16), .b(b16), .p(p16));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        return 64'(a) * 64'(b);
    endfunction

    // Drive away from the clock edge, then sample once the logic has settled.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic top_case(input string req, input logic [31:0] a, input logic [31:0] b);
        step();
        op_a = a;
        op_b = b;
        #1;
        chk(req, product, ref_mul(a, b));
    endtask

    function automatic logic [31:0] shaped(input int unsigned mode);
        case (mode % 4)
            0:       return $urandom;
            1:       return $urandom & $urandom & $urandom;
            2:       return $urandom | $urandom | $urandom;
            default: return $urandom % 256;
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] exp;
        logic [3:0]  e2;
        logic        tx, tc;
        void'($urandom(32'h5eed_0c1d));
        op_a = '0; op_b = '0;
        a2 = '0; b2 = '0; a4 = '0; b4 = '0;
        a8 = '0; b8 = '0; a16 = '0; b16 = '0;

        // R2: 2x2 cell, all 16 combinations, expected built from the bit rules.
        for (int i = 0; i < 16; i++) begin
            step();
            a2 = 2'(i);
            b2 = 2'(i >> 2);
            #1;
            tx    = (a2[1] & b2[0]) ^ (a2[0] & b2[1]);
            tc    = (a2[1] & b2[0]) & (a2[0] & b2[1]);
            e2[0] = a2[0] & b2[0];
            e2[1] = tx;
            e2[3:2] = 2'(a2[1] & b2[1]) + 2'(tc);
            chk("R2 cell2", 64'(p2), 64'(e2));
        end

        // R3: 4-bit core exhaustive.
        for (int i = 0; i < 256; i++) begin
            step();
            a4 = 4'(i);
            b4 = 4'(i >> 4);
            #1;
            chk("R3 width4", 64'(p4), 64'(a4) * 64'(b4));
        end

        // R3: 8-bit and 16-bit cores with corners and random values.
        for (int i = 0; i < 300; i++) begin
            step();
            a8  = (i == 0) ? 8'hFF : 8'($urandom);
            b8  = (i == 0) ? 8'hFF : 8'($urandom);
            a16 = (i == 0) ? 16'hFFFF : ((i == 1) ? 16'hAAAA : 16'(shaped(i)));
            b16 = (i == 0) ? 16'hFFFF : ((i == 1) ? 16'h5555 : 16'(shaped(i + 1)));
            #1;
            chk("R3 width8",  64'(p8),  64'(a8) * 64'(b8));
            chk("R3 width16", 64'(p16), 64'(a16) * 64'(b16));
        end

        // Reset-like idle state: zero operands give zero product.
        step();
        op_a = '0; op_b = '0;
        #1;
        chk("R4 idle zero", product, 64'h0);

        // R4: zero annihilates.
        top_case("R4 zero a", 32'h0, 32'hDEAD_BEEF);
        top_case("R4 zero b", 32'hFFFF_FFFF, 32'h0);

        // R5: unit operand passes the other through.
        step(); op_a = 32'h1; op_b = 32'hCAFE_F00D; #1;
        chk("R5 unit a", product, 64'h0000_0000_CAFE_F00D);
        step(); op_a = 32'hFFFF_FFFF; op_b = 32'h1; #1;
        chk("R5 unit b", product, 64'h0000_0000_FFFF_FFFF);

        // R8: longest carry path.
        step(); op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; #1;
        chk("R8 all ones", product, 64'hFFFF_FFFE_0000_0001);

        // R9: alternating patterns in both orders.
        top_case("R9 alt ab", 32'hAAAA_AAAA, 32'h5555_5555);
        exp = product;
        step(); op_a = 32'h5555_5555; op_b = 32'hAAAA_AAAA; #1;
        chk("R9 alt swap", product, exp);
        top_case("R1 alt same", 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        top_case("R1 ones x alt", 32'hFFFF_FFFF, 32'h5555_5555);
        top_case("R1 half split", 32'h0001_0000, 32'h0001_0000);
        top_case("R1 cross only", 32'hFFFF_0000, 32'h0000_FFFF);

        // R1, R6, R7, R9: shaped random operands.
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] ra, rb;
            ra = shaped(i);
            rb = shaped(i / 4 + 1);
            top_case("R1 random", ra, rb);
            chk("R6 low slice", 64'(product[15:0]),
                64'(16'(32'(ra[15:0]) * 32'(rb[15:0]))));
            if (ra != 0)
                chk("R7 bound a", 64'(product[63:32] < ra), 64'd1);
            if (i % 8 == 0) begin
                exp = product;
                step(); op_a = rb; op_b = ra; #1;
                chk("R9 swap", product, exp);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule